// File: doc/BRIEF.md
# Stack-Frame Save/Restore Sequencer

This block carries out the memory side of a compact function prologue (save) and epilogue (restore). One start pulse supplies the whole operation: a direction bit, a 3-bit mask of the return and saved registers, a count of extra callee-saved registers, a 4-bit code that splits r4..r7 into outgoing arguments and statics, and a frame size in short or extended form. From these packed fields the sequencer builds an ordered transfer list. It then walks the list one word at a time over a request/acknowledge memory port and reads or writes the register file through one shared port.

A save stores registers below the current stack pointer and then lowers the pointer by the frame size. A restore reloads the same registers from the top of the frame, sign-extends each word to register width and raises the pointer by the frame size. The stack pointer is written exactly once, at the end. An illegal argument code is refused before any memory traffic takes place.

Top module: `frame_seq`

## Requirements
- R1: In short form (`ext_form`=0) the frame size is 128 bytes when `frame_lo` is 0, and otherwise `frame_lo`×8. In this form the extra-register count and the argument code are treated as 0.
- R2: In extended form (`ext_form`=1) the frame size is {`frame_hi`,`frame_lo`}×8, so a zero field gives a size of 0.
- R3: On save, the outgoing-argument count is 0 for codes 0–3 and 11, 1 for 4–7, 2 for 8–10, 3 for 12–13 and 4 for 14. Arguments r4, r5, ... are stored first, at old SP+0, +4, +8 and +12.
- R4: After the arguments, each transfer uses a working pointer that starts at the base and is decremented by 4 before the access. The order is: r31 if `ras_mask[2]`; then the extra registers; then r17 if `ras_mask[0]`; then r16 if `ras_mask[1]`; then the statics.
- R5: The extra registers run from the highest down to r18. A count n of 1 to 6 starts at r(17+n), and a count of 7 starts at r30 and continues with r23..r18.
- R6: The static count is 0 for codes 0, 4, 8, 12 and 14; 1 for 1, 5, 9 and 13; 2 for 2, 6 and 10; 3 for 3 and 7; and 4 for 11. Statics go r7, r6, r5, r4 in that order.
- R7: A save writes each register's low 32 bits with `mem_we`=1, using the old SP as the base. It ends with a single `sp_we` pulse of SP−frame, in the cycle `done` is high.
- R8: A restore uses SP+frame as the base, follows the R4 order with no argument transfers, and issues reads (`mem_we`=0). On each acknowledge it writes the sign-extended word to the register file. It ends with a single `sp_we` of SP+frame.
- R9: Argument code 15 in extended form pulses `done` and `err` together one cycle after start. It makes no memory request and no stack-pointer write.
- R10: Only one request is outstanding at a time. `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady until `mem_ack`, and the list advances only on an acknowledge.
- R11: `busy` is high from the cycle after an accepted start until the last acknowledge. `done` is a one-cycle pulse in the cycle after that, or right after start for an empty list.
- R12: A start pulse while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| is_save | input | 1 | 1 = save, 0 = restore |
| ext_form | input | 1 | 1 = extended field form |
| ras_mask | input | 3 | bit2 r31, bit1 r16, bit0 r17 |
| xs_count | input | 3 | Extra saved register count |
| areg_code | input | 4 | Argument/static split code |
| frame_hi | input | 4 | High frame nibble (extended form) |
| frame_lo | input | 4 | Low frame nibble |
| sp_in | input | XLEN | Current stack pointer |
| busy | output | 1 | Transfers in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Illegal-code pulse (with done) |
| mem_req | output | 1 | Word request |
| mem_we | output | 1 | 1 = store |
| mem_addr | output | XLEN | Byte address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with ack |
| mem_ack | input | 1 | Request completes this cycle |
| rf_addr | output | 5 | Register file index |
| rf_rdata | input | XLEN | Register file read data (combinational) |
| rf_we | output | 1 | Register file write |
| rf_wdata | output | XLEN | Register file write data |
| sp_we | output | 1 | Stack pointer write |
| sp_wdata | output | XLEN | New stack pointer |

## Verification
The bench aims at the places where the list construction can go wrong. It covers the short-form zero frame meaning 128 and the extended-form zero meaning 0. It covers the count of 7 jumping to r30, the argument codes 11 and 14 that give four statics or four arguments, and the mask bits that put r17 before r16. A design with a wrong table, or a pointer that moves during the argument stores, shows up as a wrong address or register in the logged transfer list. Restore tests use addresses that yield both negative and positive words, so a missing or wrong sign extension is caught. Illegal code 15 and a start issued mid-operation are both applied: a partial transfer, a stray `sp_we` or a second `done` is counted as a mismatch.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  localparam int ARG_REGS   = 4;
  localparam int XTRA_MAX   = 7;
  localparam int STATIC_MAX = 4;
  localparam int MAX_XFER   = ARG_REGS + 3 + XTRA_MAX + STATIC_MAX;
  localparam int IDX_W      = $clog2(MAX_XFER + 1);
  localparam int FRAME_W    = 11;

  typedef logic [4:0] reg_idx_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/frame_seq_decode.sv
module frame_seq_decode
  import frame_seq_pkg::*;
(
  input  logic [3:0]         areg_code,
  input  logic               ext_form,
  input  logic [3:0]         frame_hi,
  input  logic [3:0]         frame_lo,
  output logic [2:0]         n_args,
  output logic [2:0]         n_static,
  output logic               illegal,
  output logic [FRAME_W-1:0] frame_bytes
);
  logic [3:0] code_eff;

  assign code_eff = ext_form ? areg_code : 4'd0;

  always_comb begin
    if (ext_form) begin
      frame_bytes = {frame_hi, frame_lo, 3'b000};
    end else if (frame_lo == 4'd0) begin
      frame_bytes = FRAME_W'(128);
    end else begin
      frame_bytes = {4'b0000, frame_lo, 3'b000};
    end
  end

  always_comb begin
    illegal = 1'b0;
    unique case (code_eff)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd11: n_args = 3'd0;
      4'd4, 4'd5, 4'd6, 4'd7:        n_args = 3'd1;
      4'd8, 4'd9, 4'd10:             n_args = 3'd2;
      4'd12, 4'd13:                  n_args = 3'd3;
      4'd14:                         n_args = 3'd4;
      default: begin
        n_args  = 3'd0;
        illegal = 1'b1;
      end
    endcase
  end

  always_comb begin
    unique case (code_eff)
      4'd0, 4'd4, 4'd8, 4'd12, 4'd14: n_static = 3'd0;
      4'd1, 4'd5, 4'd9, 4'd13:        n_static = 3'd1;
      4'd2, 4'd6, 4'd10:              n_static = 3'd2;
      4'd3, 4'd7:                     n_static = 3'd3;
      4'd11:                          n_static = 3'd4;
      default:                        n_static = 3'd0;
    endcase
  end
endmodule

// File: rtl/frame_seq_list.sv
module frame_seq_list
  import frame_seq_pkg::*;
(
  input  logic             is_save,
  input  logic [2:0]       ras_mask,
  input  logic [2:0]       xs_count,
  input  logic [2:0]       n_args,
  input  logic [2:0]       n_static,
  output reg_idx_t         list [MAX_XFER],
  output logic [IDX_W-1:0] list_len,
  output logic [IDX_W-1:0] arg_len
);
  always_comb begin
    logic [IDX_W-1:0] n;
    n = '0;
    for (int i = 0; i < MAX_XFER; i++) list[i] = '0;
    if (is_save) begin
      for (int i = 0; i < ARG_REGS; i++) begin
        if (i < int'(n_args)) begin
          list[n] = reg_idx_t'(4 + i);
          n = n + 1'b1;
        end
      end
    end
    arg_len = n;
    if (ras_mask[2]) begin
      list[n] = reg_idx_t'(31);
      n = n + 1'b1;
    end
    for (int j = XTRA_MAX; j >= 1; j--) begin
      if (j <= int'(xs_count)) begin
        list[n] = (j == XTRA_MAX) ? reg_idx_t'(30) : reg_idx_t'(17 + j);
        n = n + 1'b1;
      end
    end
    if (ras_mask[0]) begin
      list[n] = reg_idx_t'(17);
      n = n + 1'b1;
    end
    if (ras_mask[1]) begin
      list[n] = reg_idx_t'(16);
      n = n + 1'b1;
    end
    for (int k = 0; k < STATIC_MAX; k++) begin
      if (k < int'(n_static)) begin
        list[n] = reg_idx_t'(7 - k);
        n = n + 1'b1;
      end
    end
    list_len = n;
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_save,
  input  logic            ext_form,
  input  logic [2:0]      ras_mask,
  input  logic [2:0]      xs_count,
  input  logic [3:0]      areg_code,
  input  logic [3:0]      frame_hi,
  input  logic [3:0]      frame_lo,
  input  logic [XLEN-1:0] sp_in,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_ack,
  output logic [4:0]      rf_addr,
  input  logic [XLEN-1:0] rf_rdata,
  output logic            rf_we,
  output logic [XLEN-1:0] rf_wdata,
  output logic            sp_we,
  output logic [XLEN-1:0] sp_wdata
);
  localparam int WORD_W = 32;

  // decode of the packed fields
  logic [2:0]         dec_args, dec_static;
  logic               dec_illegal;
  logic [FRAME_W-1:0] dec_frame;
  logic [2:0]         xs_eff;
  reg_idx_t           gen_list [MAX_XFER];
  logic [IDX_W-1:0]   gen_len, gen_arg_len;

  assign xs_eff = ext_form ? xs_count : 3'd0;

  frame_seq_decode u_decode (
    .areg_code  (areg_code),
    .ext_form   (ext_form),
    .frame_hi   (frame_hi),
    .frame_lo   (frame_lo),
    .n_args     (dec_args),
    .n_static   (dec_static),
    .illegal    (dec_illegal),
    .frame_bytes(dec_frame)
  );

  frame_seq_list u_list (
    .is_save (is_save),
    .ras_mask(ras_mask),
    .xs_count(xs_eff),
    .n_args  (dec_args),
    .n_static(dec_static),
    .list    (gen_list),
    .list_len(gen_len),
    .arg_len (gen_arg_len)
  );

  // state
  seq_state_e         state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [IDX_W-1:0]   len_q, arg_len_q;
  reg_idx_t           list_q [MAX_XFER];
  logic               save_q;
  logic [XLEN-1:0]    sp_q, ptr_q, ptr_d;
  logic [FRAME_W-1:0] frame_q;
  logic               err_q, err_d;
  logic               accept, load_en, step_en;
  logic               in_args;

  assign accept  = start && (state_q == ST_IDLE) && !err_q;
  assign load_en = accept && !dec_illegal;
  assign in_args = (idx_q < arg_len_q);
  assign step_en = (state_q == ST_XFER) && mem_ack;

  // next state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ptr_d   = ptr_q;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (dec_illegal) begin
            err_d = 1'b1;
          end else begin
            idx_d   = '0;
            ptr_d   = is_save ? sp_in : (sp_in + XLEN'(dec_frame));
            state_d = (gen_len == '0) ? ST_FIN : ST_XFER;
          end
        end
      end
      ST_XFER: begin
        if (mem_ack) begin
          idx_d = idx_q + 1'b1;
          if (!in_args) ptr_d = ptr_q - XLEN'(4);
          if (idx_q + 1'b1 == len_q) state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ptr_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (load_en || step_en) begin
        idx_q <= idx_d;
        ptr_q <= ptr_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q     <= '0;
      arg_len_q <= '0;
      save_q    <= 1'b0;
      sp_q      <= '0;
      frame_q   <= '0;
      for (int i = 0; i < MAX_XFER; i++) list_q[i] <= '0;
    end else if (load_en) begin
      len_q     <= gen_len;
      arg_len_q <= gen_arg_len;
      save_q    <= is_save;
      sp_q      <= sp_in;
      frame_q   <= dec_frame;
      for (int i = 0; i < MAX_XFER; i++) list_q[i] <= gen_list[i];
    end
  end

  // memory and register-file side
  reg_idx_t cur_reg;
  assign cur_reg = (idx_q < IDX_W'(MAX_XFER)) ? list_q[idx_q] : '0;

  assign busy      = (state_q == ST_XFER);
  assign mem_req   = busy;
  assign mem_we    = busy && save_q;
  assign mem_addr  = in_args ? (sp_q + XLEN'({idx_q, 2'b00})) : (ptr_q - XLEN'(4));
  assign mem_wdata = save_q ? rf_rdata[WORD_W-1:0] : '0;
  assign rf_addr   = busy ? cur_reg : '0;
  assign rf_we     = busy && !save_q && mem_ack;

  generate
    if (XLEN > WORD_W) begin : g_sext
      assign rf_wdata = {{(XLEN-WORD_W){mem_rdata[WORD_W-1]}}, mem_rdata};
    end else begin : g_plain
      assign rf_wdata = mem_rdata[XLEN-1:0];
    end
  endgenerate

  assign done     = (state_q == ST_FIN) || err_q;
  assign err      = err_q;
  assign sp_we    = (state_q == ST_FIN);
  assign sp_wdata = save_q ? (sp_q - XLEN'(frame_q)) : (sp_q + XLEN'(frame_q));
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [XLEN-1:0] mem_addr,
  input logic [31:0]     mem_wdata,
  input logic            rf_we,
  input logic            sp_we
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req); // R10
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_we)); // R10
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_ack |=> $stable(mem_wdata)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_REQ_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R11
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !mem_req && !sp_we); // R9
  AST_SP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> done && !err && !busy); // R7
  AST_RF_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mem_req && mem_ack && !mem_we); // R8
endmodule

bind frame_seq frame_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .rf_we    (rf_we),
  .sp_we    (sp_we)
);

// File: tb/frame_seq_tb.sv
`timescale 1ns/1ps
module frame_seq_tb;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            start = 0, is_save = 0, ext_form = 0;
  logic [2:0]      ras_mask = 0, xs_count = 0;
  logic [3:0]      areg_code = 0, frame_hi = 0, frame_lo = 0;
  logic [XLEN-1:0] sp_in = 0;
  logic            busy, done, err, mem_req, mem_we, mem_ack = 0;
  logic [XLEN-1:0] mem_addr, rf_rdata, rf_wdata, sp_wdata;
  logic [31:0]     mem_wdata, mem_rdata = 0;
  logic [4:0]      rf_addr;
  logic            rf_we, sp_we;

  frame_seq #(.XLEN(XLEN)) u_dut (.*);

  function automatic logic [XLEN-1:0] rf_val(input logic [4:0] r);
    return {32'hC0DE_0000 | 32'(r), 32'h5A00_0000 | (32'(r) * 32'h0101)};
  endfunction
  function automatic logic [31:0] mem_val(input logic [XLEN-1:0] a);
    return a[31:0] ^ 32'h9E37_0000;
  endfunction
  assign rf_rdata = rf_val(rf_addr);

  int n_chk = 0, n_bad = 0, cyc = 0;
  int lat = 0, wait_cnt = 0;

  // logs
  logic [XLEN-1:0] g_addr [64];
  logic            g_we   [64];
  logic [31:0]     g_wd   [64];
  int              g_n;
  logic [4:0]      w_reg  [64];
  logic [XLEN-1:0] w_dat  [64];
  int              w_n, sp_n, done_n, err_n, busy_cyc, req_cyc;
  logic [XLEN-1:0] sp_val;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0;
      wait_cnt = 0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        mem_rdata = mem_val(mem_addr);
        mem_ack = 1;
      end else wait_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_req && mem_ack && g_n < 64) begin
        g_addr[g_n] = mem_addr; g_we[g_n] = mem_we; g_wd[g_n] = mem_wdata; g_n++;
      end
      if (rf_we && w_n < 64) begin
        w_reg[w_n] = rf_addr; w_dat[w_n] = rf_wdata; w_n++;
      end
      if (sp_we) begin sp_n++; sp_val = sp_wdata; end
      if (done) done_n++;
      if (err) err_n++;
      if (busy) busy_cyc++;
      if (mem_req) req_cyc++;
    end
  end

  // expected model
  logic [4:0]      e_reg  [32];
  logic [XLEN-1:0] e_addr [32];
  int              e_n;

  task automatic build_exp(input bit sv, input bit ex, input logic [2:0] rm, input logic [2:0] xs,
                           input logic [3:0] code, input logic [3:0] hi, input logic [3:0] lo,
                           input logic [XLEN-1:0] sp, output logic [XLEN-1:0] sp_exp);
    int fr, na, ns, xc;
    logic [XLEN-1:0] p;
    logic [3:0] c;
    c  = ex ? code : 4'd0;
    xc = ex ? int'(xs) : 0;
    if (ex) fr = (int'(hi) * 16 + int'(lo)) * 8;
    else fr = (lo == 0) ? 128 : int'(lo) * 8;
    if (c == 14) na = 4; else if (c >= 12) na = 3; else if (c == 11) na = 0;
    else if (c >= 8) na = 2; else if (c >= 4) na = 1; else na = 0;
    if (c == 11) ns = 4; else if (c == 14 || c[1:0] == 2'd0) ns = 0; else ns = int'(c[1:0]);
    if (c == 13) ns = 1;
    e_n = 0;
    if (sv) for (int i = 0; i < na; i++) begin
      e_reg[e_n] = 5'(4 + i); e_addr[e_n] = sp + XLEN'(4 * i); e_n++;
    end
    p = sv ? sp : sp + XLEN'(fr);
    if (rm[2]) begin p -= 4; e_reg[e_n] = 31; e_addr[e_n] = p; e_n++; end
    for (int j = xc; j >= 1; j--) begin
      p -= 4; e_reg[e_n] = (j == 7) ? 5'd30 : 5'(17 + j); e_addr[e_n] = p; e_n++;
    end
    if (rm[0]) begin p -= 4; e_reg[e_n] = 17; e_addr[e_n] = p; e_n++; end
    if (rm[1]) begin p -= 4; e_reg[e_n] = 16; e_addr[e_n] = p; e_n++; end
    for (int k = 0; k < ns; k++) begin
      p -= 4; e_reg[e_n] = 5'(7 - k); e_addr[e_n] = p; e_n++;
    end
    sp_exp = sv ? sp - XLEN'(fr) : sp + XLEN'(fr);
  endtask

  task automatic run_op(input string tag, input bit sv, input bit ex, input logic [2:0] rm,
                        input logic [2:0] xs, input logic [3:0] code, input logic [3:0] hi,
                        input logic [3:0] lo, input logic [XLEN-1:0] sp, input int latency,
                        input bit poke);
    logic [XLEN-1:0] sp_exp;
    int t;
    build_exp(sv, ex, rm, xs, code, hi, lo, sp, sp_exp);
    @(negedge clk);
    lat = latency;
    g_n = 0; w_n = 0; sp_n = 0; done_n = 0; err_n = 0; busy_cyc = 0; req_cyc = 0;
    is_save = sv; ext_form = ex; ras_mask = rm; xs_count = xs; areg_code = code;
    frame_hi = hi; frame_lo = lo; sp_in = sp; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      areg_code = 4'd15; ext_form = 1; is_save = ~sv; start = 1;   // R12 stimulus
      @(negedge clk);
      start = 0;
    end
    t = 0;
    while (done_n == 0 && t < 4000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(done_n == 1, {tag, " R11 done pulses"}, done_n, 1);
    chk(busy == 0 && mem_req == 0, {tag, " R11 idle after"}, {busy, mem_req}, 0);
    chk(err_n == 0, {tag, " R12 no err"}, err_n, 0);
    chk(g_n == e_n, {tag, " R4 transfer count"}, g_n, e_n);
    chk(busy_cyc == req_cyc && (e_n == 0 || busy_cyc >= e_n * (latency + 1)),
        {tag, " R11 busy span"}, busy_cyc, e_n * (latency + 1));
    for (int i = 0; i < e_n && i < g_n; i++) begin
      chk(g_addr[i] == e_addr[i], $sformatf("%s R4 addr[%0d]", tag, i), g_addr[i], e_addr[i]);
      chk(g_we[i] == sv, $sformatf("%s R7 we[%0d]", tag, i), g_we[i], sv);
      if (sv)
        chk(g_wd[i] == rf_val(e_reg[i])[31:0], $sformatf("%s R7 data r%0d", tag, e_reg[i]),
            g_wd[i], rf_val(e_reg[i])[31:0]);
    end
    if (sv) chk(w_n == 0, {tag, " R7 no rf write"}, w_n, 0);
    else begin
      chk(w_n == e_n, {tag, " R8 rf write count"}, w_n, e_n);
      for (int i = 0; i < e_n && i < w_n; i++) begin
        logic [XLEN-1:0] ev;
        ev = XLEN'($signed(mem_val(e_addr[i])));
        chk(w_reg[i] == e_reg[i], $sformatf("%s R8 rf reg[%0d]", tag, i), w_reg[i], e_reg[i]);
        chk(w_dat[i] == ev, $sformatf("%s R8 sext[%0d]", tag, i), w_dat[i], ev);
      end
    end
    chk(sp_n == 1, {tag, " R7 sp written once"}, sp_n, 1);
    chk(sp_val == sp_exp, {tag, " R7/R8 sp value"}, sp_val, sp_exp);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !err && !mem_req && !sp_we && !rf_we, "R11 reset outputs",
        {busy, done, err, mem_req, sp_we, rf_we}, 0);
  endtask
  task automatic t_short_zero;   // R1: lo=0 -> 128
    run_op("R1 short zero", 1, 0, 3'b111, 3'd5, 4'd9, 4'd7, 4'd0, 64'h0000_0000_0001_0000, 0, 0);
  endtask
  task automatic t_short_nz;     // R1
    run_op("R1 short five", 1, 0, 3'b100, 3'd0, 4'd0, 4'd0, 4'd5, 64'h0000_0000_0002_0040, 1, 0);
  endtask
  task automatic t_ext_args4;    // R2 R3 R5
    run_op("R3 R5 ext code14 xs7", 1, 1, 3'b111, 3'd7, 4'd14, 4'd1, 4'd2, 64'h0000_0000_0003_0100, 0, 0);
  endtask
  task automatic t_ext_static4;  // R6
    run_op("R6 code11 xs3", 1, 1, 3'b011, 3'd3, 4'd11, 4'd0, 4'd4, 64'h0000_0000_0004_0200, 2, 0);
  endtask
  task automatic t_ext_mix;      // R3 R6 R10 latency
    run_op("R10 code9 lat3", 1, 1, 3'b001, 3'd2, 4'd9, 4'd3, 4'd0, 64'h0000_0000_0005_0300, 3, 0);
  endtask
  task automatic t_ext_zero;     // R2: zero extended frame
    run_op("R2 ext zero", 1, 1, 3'b010, 3'd1, 4'd13, 4'd0, 4'd0, 64'h0000_0000_0006_0000, 0, 0);
  endtask
  task automatic t_restore_neg;  // R8 negative words
    run_op("R8 restore neg", 0, 1, 3'b111, 3'd7, 4'd11, 4'd2, 4'd0, 64'h0000_0000_0007_0000, 1, 0);
  endtask
  task automatic t_restore_pos;  // R8 positive words, args ignored
    run_op("R8 restore pos", 0, 1, 3'b110, 3'd4, 4'd14, 4'd0, 4'd8, 64'h0000_0000_8000_1000, 0, 0);
  endtask
  task automatic t_restore_short;
    run_op("R8 R1 restore short", 0, 0, 3'b010, 3'd0, 4'd0, 4'd0, 4'd3, 64'h0000_0000_0008_0000, 2, 0);
  endtask
  task automatic t_empty;        // R11 empty list
    run_op("R11 empty", 1, 0, 3'b000, 3'd0, 4'd0, 4'd0, 4'd1, 64'h0000_0000_0009_0000, 0, 0);
  endtask
  task automatic t_busy_start;   // R12
    run_op("R12 start while busy", 1, 1, 3'b111, 3'd6, 4'd7, 4'd0, 4'd9, 64'h0000_0000_000A_0000, 2, 1);
  endtask
  task automatic t_illegal;      // R9
    int t;
    @(negedge clk);
    g_n = 0; sp_n = 0; done_n = 0; err_n = 0; req_cyc = 0; busy_cyc = 0;
    is_save = 1; ext_form = 1; areg_code = 4'd15; ras_mask = 3'b111; xs_count = 3'd7;
    frame_hi = 4'd1; frame_lo = 4'd1; start = 1;
    @(negedge clk);
    start = 0;
    chk(done && err, "R9 done+err one cycle after start", {done, err}, 2'b11);
    t = 0;
    repeat (10) @(negedge clk);
    chk(done_n == 1 && err_n == 1, "R9 single pulse", {done_n[7:0], err_n[7:0]}, 16'h0101);
    chk(req_cyc == 0 && busy_cyc == 0, "R9 no memory access", req_cyc, 0);
    chk(sp_n == 0, "R9 no sp write", sp_n, 0);
    areg_code = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_short_zero();
    t_short_nz();
    t_ext_args4();
    t_ext_static4();
    t_ext_mix();
    t_ext_zero();
    t_restore_neg();
    t_restore_pos();
    t_restore_short();
    t_empty();
    t_illegal();
    t_busy_start();
    t_short_zero();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule